// File: doc/BRIEF.md
# Vector Length Setting Unit

This block carries out the "set vector length" management operation against a 64-bit vector state register that it holds internally. Each accepted operation can set the maximum vector length from an immediate and set the working vector length. The length can come from a source register, from the immediate or from a count register. It then saturates the length twice: first to 127 and then to the maximum length, and it raises an overflow flag when either limit applies. The operation can also switch vertical-first mode and clear the remap-persistence bit.

An operation is presented for one cycle with `valid_i` high. All results appear registered on the next cycle: the updated state, a one-cycle destination write strobe with the zero-extended length, an overflow pulse, and an optional condition-record pulse. A separate load port replaces the whole state word, as a context restore would. Register-file storage and instruction decode live outside the block.

The state word uses LSB-0 numbering. Bits [63:57] hold the maximum length, bits [56:50] hold the length, bit 1 holds the remap-persistence bit and bit 0 holds the vertical-first bit.

Top module: `vlset_unit`

## Requirements
- R1: During and after reset, `state_o` is zero and `wr_en_o`, `ovf_o` and `cr_we_o` are low.
- R2: With `ms_i`=1, the maximum length (state[63:57]) becomes `imm_i`+1 truncated to 7 bits, so an immediate of 127 gives 0. With `ms_i`=0, the maximum length is kept.
- R3: With `vs_i`=0, the length (state[56:50]) is kept, subject to the clamp of R6, and no source overflow is raised.
- R4: With `vs_i`=1, the length source is `ra_val_i` if `ra_idx_i`≠0. Otherwise it is the immediate length (`imm_i`+1, 7 bits) if `rt_idx_i`=0. Otherwise it is `ctr_i`.
- R5: A register or count source above 127 (unsigned) gives a length of 127 and sets overflow. A smaller value gives its low 7 bits.
- R6: If the length exceeds the new maximum length, it is clamped to the maximum length and overflow is set, so the stored length never exceeds the stored maximum.
- R7: If `rt_idx_i`≠0, `wr_en_o` pulses one cycle after `valid_i` with `wr_data_o` equal to the final length zero-extended to 64 bits. If `rt_idx_i`=0, there is no write.
- R8: Unless `vs_i` and `ms_i` are both 0, state bit 0 takes `vf_i` and state bit 1 is cleared. Otherwise both bits are kept.
- R9: State bits [49:2] pass through every operation unchanged. The state does not change in a cycle without `valid_i` or `load_i`.
- R10: With `rc_i`=1, `cr_we_o` pulses with `cr_o` = {negative=0, positive=(length≠0), zero=(length=0), overflow}, from bit 3 down to bit 0.
- R11: `load_i` replaces the state with `load_data_i` on the next edge, but it is ignored in a cycle where `valid_i` is high.
- R12: `ovf_o` pulses for one cycle after an operation that overflowed. The effects of one operation are visible to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Operation strobe |
| imm_i | input | 7 | Immediate (length minus one) |
| ms_i | input | 1 | Set maximum length |
| vs_i | input | 1 | Set length |
| vf_i | input | 1 | Vertical-first request |
| rc_i | input | 1 | Request condition-record update |
| ra_idx_i | input | 5 | Source register index |
| rt_idx_i | input | 5 | Destination register index |
| ra_val_i | input | 64 | Source register value |
| ctr_i | input | 64 | Count register value |
| load_i | input | 1 | Whole-state load strobe |
| load_data_i | input | 64 | State value to load |
| state_o | output | 64 | Current state register |
| wr_en_o | output | 1 | Destination write strobe |
| wr_data_o | output | 64 | Destination write data |
| ovf_o | output | 1 | Overflow pulse |
| cr_we_o | output | 1 | Condition-record strobe |
| cr_o | output | 4 | Condition-record value |

## Verification
The bench loads a patterned state and then goes after the two saturation stages separately and together. It drives a source just above 127 with a small maximum, and a count of all ones. A design that merged or skipped either stage would report a wrong length or miss the overflow. An immediate of 127 must wrap the maximum to zero and force the length to zero. A design that kept the carry would read it as 128. The bench exercises all three source choices, including the case where a non-zero destination index selects the count register. It covers the case where both set bits are clear, which must leave the mode bits alone, and a load issued together with an operation, which must be dropped. Randomised operations then check pass-through of the unrelated state bits against an independent model.

// File: rtl/vlset_unit.sv
module vlset_unit #(
  parameter int XLEN = 64,
  parameter int LW   = 7,
  parameter int IW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_i,
  input  logic [LW-1:0]   imm_i,
  input  logic            ms_i,
  input  logic            vs_i,
  input  logic            vf_i,
  input  logic            rc_i,
  input  logic [IW-1:0]   ra_idx_i,
  input  logic [IW-1:0]   rt_idx_i,
  input  logic [XLEN-1:0] ra_val_i,
  input  logic [XLEN-1:0] ctr_i,
  input  logic            load_i,
  input  logic [XLEN-1:0] load_data_i,
  output logic [XLEN-1:0] state_o,
  output logic            wr_en_o,
  output logic [XLEN-1:0] wr_data_o,
  output logic            ovf_o,
  output logic            cr_we_o,
  output logic [3:0]      cr_o
);
  localparam int MX_HI = XLEN - 1;
  localparam int MX_LO = XLEN - LW;
  localparam int LN_HI = XLEN - LW - 1;
  localparam int LN_LO = XLEN - 2 * LW;
  localparam int VF_B  = 0;
  localparam int PS_B  = 1;
  localparam logic [LW-1:0] LTOP = {LW{1'b1}};

  logic [XLEN-1:0] st_q, st_nx;
  logic [LW-1:0]   imm_len, mx_nx, src_len, len_pre, len_nx;
  logic            src_ovf, clamp, ovf_nx;

  function automatic logic [LW:0] sat7(input logic [XLEN-1:0] v);
    if (v > XLEN'(LTOP)) return {1'b1, LTOP};
    return {1'b0, v[LW-1:0]};
  endfunction

  assign imm_len = imm_i + LW'(1);
  assign mx_nx   = ms_i ? imm_len : st_q[MX_HI:MX_LO];

  always_comb begin
    if (ra_idx_i != '0)      {src_ovf, src_len} = sat7(ra_val_i);
    else if (rt_idx_i == '0) {src_ovf, src_len} = {1'b0, imm_len};
    else                     {src_ovf, src_len} = sat7(ctr_i);
  end

  assign len_pre = vs_i ? src_len : st_q[LN_HI:LN_LO];
  assign clamp   = len_pre > mx_nx;
  assign len_nx  = clamp ? mx_nx : len_pre;
  assign ovf_nx  = (vs_i & src_ovf) | clamp;

  always_comb begin
    st_nx = st_q;
    st_nx[MX_HI:MX_LO] = mx_nx;
    st_nx[LN_HI:LN_LO] = len_nx;
    if (vs_i | ms_i) begin
      st_nx[VF_B] = vf_i;
      st_nx[PS_B] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= '0;
      wr_en_o   <= 1'b0;
      wr_data_o <= '0;
      ovf_o     <= 1'b0;
      cr_we_o   <= 1'b0;
      cr_o      <= '0;
    end else begin
      wr_en_o <= 1'b0;
      ovf_o   <= 1'b0;
      cr_we_o <= 1'b0;
      if (valid_i) begin
        st_q      <= st_nx;
        wr_en_o   <= rt_idx_i != '0;
        wr_data_o <= {{(XLEN-LW){1'b0}}, len_nx};
        ovf_o     <= ovf_nx;
        cr_we_o   <= rc_i;
        cr_o      <= {1'b0, |len_nx, ~|len_nx, ovf_nx};
      end else if (load_i) begin
        st_q <= load_data_i;
      end
    end
  end

  assign state_o = st_q;

  // R6
  len_in_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(valid_i) |-> state_o[LN_HI:LN_LO] <= state_o[MX_HI:MX_LO]);

  // R7
  wr_matches_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> wr_data_o == {{(XLEN-LW){1'b0}}, state_o[LN_HI:LN_LO]});

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(valid_i) && !$past(load_i)) |-> $stable(state_o));

  // R9
  mid_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(valid_i) |-> state_o[LN_LO-1:PS_B+1] == $past(state_o[LN_LO-1:PS_B+1]));

  // R8
  mode_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(valid_i) && !$past(vs_i) && !$past(ms_i)) |->
      state_o[PS_B:VF_B] == $past(state_o[PS_B:VF_B]));

  // R10
  cr_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we_o |-> (cr_o[0] == ovf_o && !cr_o[3] && $onehot(cr_o[2:1])));
endmodule

// File: tb/vlset_unit_bench.sv
module vlset_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0, ms_i = 1'b0, vs_i = 1'b0, vf_i = 1'b0, rc_i = 1'b0, load_i = 1'b0;
  logic [6:0] imm_i = '0;
  logic [4:0] ra_idx_i = '0, rt_idx_i = '0;
  logic [63:0] ra_val_i = '0, ctr_i = '0, load_data_i = '0;
  logic [63:0] state_o, wr_data_o;
  logic wr_en_o, ovf_o, cr_we_o;
  logic [3:0] cr_o;

  always #2 clk = ~clk;

  vlset_unit u_vlset_unit (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .imm_i(imm_i), .ms_i(ms_i),
    .vs_i(vs_i), .vf_i(vf_i), .rc_i(rc_i), .ra_idx_i(ra_idx_i), .rt_idx_i(rt_idx_i),
    .ra_val_i(ra_val_i), .ctr_i(ctr_i), .load_i(load_i), .load_data_i(load_data_i),
    .state_o(state_o), .wr_en_o(wr_en_o), .wr_data_o(wr_data_o), .ovf_o(ovf_o),
    .cr_we_o(cr_we_o), .cr_o(cr_o));

  typedef struct {
    logic [63:0] st;
    logic        we;
    logic [63:0] wd;
    logic        ovf;
    logic        crwe;
    logic [3:0]  cr;
    string       tag;
  } exp_t;

  exp_t q[$];
  logic [63:0] st_m = '0;
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(logic [6:0] imm, logic ms, logic vs, logic vf, logic rc,
                                 logic [4:0] ra, logic [4:0] rt, logic [63:0] rav,
                                 logic [63:0] ctr, string tag);
    exp_t e;
    logic [6:0] il, mx, ln;
    logic ov;
    logic [63:0] s;
    il = 7'((int'(imm) + 1) % 128);
    mx = ms ? il : st_m[63:57];
    ov = 1'b0;
    ln = st_m[56:50];
    if (vs) begin
      if (ra != 0) s = rav;
      else if (rt == 0) s = {57'd0, il};
      else s = ctr;
      if (s > 64'd127) begin ln = 7'd127; ov = 1'b1; end
      else ln = s[6:0];
    end
    if (ln > mx) begin ln = mx; ov = 1'b1; end
    e.st = st_m;
    e.st[63:57] = mx;
    e.st[56:50] = ln;
    if (vs || ms) begin e.st[0] = vf; e.st[1] = 1'b0; end
    e.we = (rt != 0);
    e.wd = {57'd0, ln};
    e.ovf = ov;
    e.crwe = rc;
    e.cr = {1'b0, ln != 0, ln == 0, ov};
    e.tag = tag;
    return e;
  endfunction

  task automatic op(logic [6:0] imm, logic ms, logic vs, logic vf, logic rc,
                    logic [4:0] ra, logic [4:0] rt, logic [63:0] rav, logic [63:0] ctr,
                    string tag, logic ld = 1'b0, logic [63:0] ldv = '0);
    exp_t e;
    @(negedge clk);
    imm_i = imm; ms_i = ms; vs_i = vs; vf_i = vf; rc_i = rc;
    ra_idx_i = ra; rt_idx_i = rt; ra_val_i = rav; ctr_i = ctr;
    load_i = ld; load_data_i = ldv; valid_i = 1'b1;
    e = model(imm, ms, vs, vf, rc, ra, rt, rav, ctr, tag);
    @(posedge clk);
    #1;
    st_m = e.st;
    q.push_back(e);
    @(negedge clk);
    valid_i = 1'b0; load_i = 1'b0;
  endtask

  task automatic load_st(logic [63:0] v);
    @(negedge clk);
    load_i = 1'b1; load_data_i = v;
    @(negedge clk);
    load_i = 1'b0;
    st_m = v;
    chk("R11", "load", state_o, v);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, "state", state_o, e.st);
      chk("R7", "wr_en", {63'd0, wr_en_o}, {63'd0, e.we});
      if (e.we) chk("R7", "wr_data", wr_data_o, e.wd);
      chk("R12", "ovf", {63'd0, ovf_o}, {63'd0, e.ovf});
      chk("R10", "cr_we", {63'd0, cr_we_o}, {63'd0, e.crwe});
      if (e.crwe) chk("R10", "cr", {60'd0, cr_o}, {60'd0, e.cr});
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "state in reset", state_o, 64'd0);
    chk("R1", "strobes in reset", {61'd0, wr_en_o, ovf_o, cr_we_o}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "state after reset", state_o, 64'd0);

    load_st(64'h0002_AAAA_5555_5557);
    // R2 R4 immediate source: max 16, length 16
    op(7'd15, 1, 1, 1, 1, 0, 0, 0, 0, "R2");
    // R4 register source, write to rt
    op(7'd7, 1, 1, 0, 1, 5'd3, 5'd4, 64'd5, 64'd99, "R4");
    // R5 R6 source 128 saturates, then clamps to 8
    op(7'd7, 0, 1, 1, 1, 5'd3, 5'd4, 64'd128, 0, "R5");
    // R5 max 127, big source saturates
    op(7'd126, 1, 1, 0, 1, 5'd1, 5'd2, 64'd1000, 0, "R5");
    // R4 count source chosen when ra=0, rt!=0
    op(7'd0, 0, 1, 1, 1, 0, 5'd9, 64'd7, 64'd50, "R4");
    // R5 count of all ones
    op(7'd0, 0, 1, 0, 1, 0, 5'd9, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R5");
    // R3 R8 keep length and modes when vs=ms=0
    load_st(64'h0000_0000_0000_0003 | {7'd100, 7'd90, 50'd0});
    op(7'd3, 0, 0, 0, 1, 0, 5'd1, 0, 0, "R3");
    op(7'd3, 0, 0, 1, 0, 5'd2, 0, 64'd2, 0, "R8");
    // R6 set max 4 with vs=0 forces clamp of kept 90
    op(7'd3, 1, 0, 0, 1, 0, 5'd1, 0, 0, "R6");
    // R2 immediate 127 wraps max to 0
    op(7'd127, 1, 1, 1, 1, 0, 0, 0, 0, "R2");
    // R11 load ignored alongside operation
    op(7'd20, 1, 1, 0, 1, 0, 0, 0, 0, "R11", 1'b1, 64'h1234_5678_9ABC_DEF0);
    // R9 idle holds state
    repeat (4) @(negedge clk);
    chk("R9", "idle state", state_o, st_m);
    load_st(64'hFFFF_FFFF_FFFF_FFFF);
    for (int i = 0; i < 60; i++) begin
      logic [31:0] r;
      r = $urandom;
      op(7'($urandom), r[0], r[1], r[2], r[3], r[4] ? 5'(r[9:5]) : 5'd0,
         r[10] ? 5'(r[15:11]) : 5'd0,
         r[16] ? 64'($urandom % 200) : {$urandom, $urandom},
         r[17] ? 64'($urandom % 200) : {$urandom, $urandom}, "R9");
    end
    repeat (3) @(negedge clk);
    chk("R9", "final state", state_o, st_m);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule